// File: doc/BRIEF.md
# SPI Flash Erase-Program Sequencer

This block copies a run of bytes into a serial NOR flash over a single-lane SPI link. The user side gives a 24-bit start address and a byte count, then pulses `start`. For every 4 KB sector the run touches, the sequencer sends a write-enable frame and then a sector-erase frame. It then polls the status register until the device reports idle. After that it writes the bytes in page-sized chunks, and it sends write enable before each chunk and polls for idle after it.

Bytes come in one at a time through a request/valid handshake. No page buffer sits inside the block, and the SPI clock simply pauses while a byte is pending. A poll-count ceiling stops a device that never goes idle from hanging the sequence. When that ceiling is hit, the block raises `error` instead of `done`.

Top module: `flashProgSeq`

## Requirements
- R1: The SPI link runs in mode 0. SCLK idles low and changes only while chip select is low. MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge. Every byte goes out most significant bit first.
- R2: Every erase frame and every program frame is directly preceded by a frame holding only the byte 0x06. Chip select goes high between that frame and the command that follows it.
- R3: Each 4 KB sector the run touches is erased exactly once per run. The erase happens before the first program into that sector, and sectors are erased in ascending address order. An erase frame is 0x20 followed by the sector base address as three bytes, most significant first, which clears the whole sector including bytes outside the run.
- R4: A program frame is 0x02, then a three-byte address (most significant first), then 1 to 256 data bytes. A frame never crosses a 256-byte page boundary. The first chunk is 256 minus the low address byte, capped at the bytes left, and each later chunk is a full page or the remainder.
- R5: After every erase or program frame, the block sends two-byte frames (0x05, then a dummy byte) again and again until bit 0 of the returned byte reads 0. No other command goes out in between.
- R6: Chip select stays high for at least DESEL_CYC clock cycles between frames. This time is never less than one SCLK period (2·HALF_DIV cycles). SCLK is low whenever chip select is high.
- R7: `dataReq` is high only inside a program frame while the block waits for its next byte. A byte is taken in a cycle where both `dataReq` and `dataVld` are high. Exactly byteLen bytes are taken, in address order, and they land at startAddr onward.
- R8: If POLL_MAX polls in a row all read busy, the sequence stops with chip select high. `error` then stays high until the next accepted start, and no `done` is given. If the device reads idle on the last allowed poll, the sequence continues normally.
- R9: `done` is a single-cycle pulse when the run completes, and it never coincides with `error`. `busy` is high from the accepted start until completion. A byte count of zero gives `done` without any SPI frame.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: Out of reset, chip select is high, SCLK is low, and `busy`, `done`, `error` and `dataReq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only while idle) |
| startAddr | input | 24 | First flash byte address of the run |
| byteLen | input | LEN_W | Number of bytes to write |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: run finished |
| error | output | 1 | Poll ceiling hit; held until next start |
| dataReq | output | 1 | Next data byte wanted |
| dataVld | input | 1 | `dataIn` holds the requested byte |
| dataIn | input | 8 | Data byte |
| sclk | output | 1 | SPI serial clock |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |

## Verification
The tightest collision is between the status poll that first reads idle and the poll counter reaching its ceiling. Both are decided on the same close of a poll frame. The bench's flash model is set to report busy for exactly POLL_MAX−1 polls, so idle arrives on the last permitted poll. The run must then finish with `done` and no `error`, with the poll count matching. A second run with one more busy poll must end in `error`, with no program frame issued.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;

  // Command bytes understood by the attached flash
  localparam logic [7:0] OP_WREN        = 8'h06;
  localparam logic [7:0] OP_SECT_ERASE  = 8'h20;
  localparam logic [7:0] OP_PAGE_PROG   = 8'h02;
  localparam logic [7:0] OP_READ_STATUS = 8'h05;

  localparam int PAGE_BYTES  = 256;
  localparam int ADDR_BYTES  = 3;

  // Strobes from the control FSM to the SPI datapath
  typedef struct packed {
    logic       send;    // load txByte and shift one byte
    logic       csOn;    // drop chip select together with send
    logic       csOff;   // raise chip select, start deselect timer
    logic [7:0] txByte;
  } spiStrobe_t;

  typedef enum logic [1:0] {
    FR_WREN,
    FR_ERASE,
    FR_PROG,
    FR_POLL
  } frameKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_FRAME,
    ST_DONE,
    ST_FAIL
  } seqState_t;

endpackage

// File: rtl/flashSpiShifter.sv
module flashSpiShifter
  import flashSeqPkg::*;
#(
  parameter int HALF_DIV  = 2,  // system cycles per SCLK half period
  parameter int DESEL_CYC = 8   // requested chip-select high time
) (
  input  logic       clk,
  input  logic       rstN,
  input  spiStrobe_t strb,
  output logic       ready,
  output logic [7:0] rxByte,
  output logic       sclk,
  output logic       csN,
  output logic       mosi,
  input  logic       miso
);

  localparam int DIV_W     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int DESEL_MIN = 2 * HALF_DIV;
  localparam int DESEL_EFF = (DESEL_CYC > DESEL_MIN) ? DESEL_CYC : DESEL_MIN;
  localparam int DSL_W     = $clog2(DESEL_EFF + 1);

  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic             active;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;
  logic [DSL_W-1:0] deselCnt;
  logic             halfTick;

  assign halfTick = (divCnt == DIV_W'(HALF_DIV - 1));
  assign ready    = !active && (deselCnt == '0);
  assign rxByte   = rxSh;
  assign mosi     = txSh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      bitCnt   <= '0;
      active   <= 1'b0;
      txSh     <= '0;
      rxSh     <= '0;
      sclk     <= 1'b0;
      csN      <= 1'b1;
      deselCnt <= '0;
    end else begin
      if (strb.send) begin
        txSh   <= strb.txByte;
        active <= 1'b1;
        divCnt <= '0;
        bitCnt <= '0;
        sclk   <= 1'b0;
        if (strb.csOn) csN <= 1'b0;
      end else if (active) begin
        if (halfTick) begin
          divCnt <= '0;
          if (!sclk) begin
            // rising edge: capture the flash output
            sclk <= 1'b1;
            rxSh <= {rxSh[6:0], miso};
          end else begin
            // falling edge: present the next bit
            sclk   <= 1'b0;
            txSh   <= {txSh[6:0], 1'b0};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) active <= 1'b0;
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end

      if (strb.csOff) begin
        csN      <= 1'b1;
        deselCnt <= DSL_W'(DESEL_EFF);
      end else if (deselCnt != '0) begin
        deselCnt <= deselCnt - DSL_W'(1);
      end
    end
  end

endmodule

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int POLL_MAX = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [23:0]      startAddr,
  input  logic [LEN_W-1:0] byteLen,
  input  logic             dataVld,
  input  logic [7:0]       dataIn,
  input  logic             ready,
  input  logic [7:0]       rxByte,
  output spiStrobe_t       strb,
  output logic             dataReq,
  output logic             busy,
  output logic             done,
  output logic             error
);

  localparam int CMP_W = (LEN_W > 9) ? LEN_W : 9;
  localparam int PC_W  = $clog2(POLL_MAX + 1);
  localparam int HDR_N = 1 + ADDR_BYTES;

  seqState_t        state;
  frameKind_t       kind;
  logic [9:0]       byteIdx;
  logic [23:0]      curAddr;
  logic [LEN_W-1:0] remaining;
  logic [11:0]      lastSector;
  logic             anyErased;
  logic             eraseStep;
  logic [PC_W-1:0]  pollCnt;

  logic [8:0]       pageRoom;
  logic [CMP_W-1:0] remExt;
  logic [8:0]       chunkLen;
  logic [9:0]       frameLen;
  logic [23:0]      frameAddr;
  logic [7:0]       hdrByte;
  logic             statusBusy;
  logic             unusedStatus;

  assign statusBusy   = rxByte[0];
  assign unusedStatus = ^rxByte[7:1];

  // Bytes to the end of the current page, capped by what is left
  assign pageRoom = 9'd256 - {1'b0, curAddr[7:0]};
  assign remExt   = CMP_W'(remaining);
  assign chunkLen = (remExt < CMP_W'(pageRoom)) ? 9'(remExt) : pageRoom;

  always_comb begin
    case (kind)
      FR_WREN:  frameLen = 10'd1;
      FR_ERASE: frameLen = 10'(HDR_N);
      FR_POLL:  frameLen = 10'd2;
      default:  frameLen = 10'(HDR_N) + {1'b0, chunkLen};
    endcase
  end

  assign frameAddr = (kind == FR_ERASE) ? {curAddr[23:12], 12'h000} : curAddr;

  always_comb begin
    hdrByte = 8'h00;
    case (byteIdx)
      10'd0: begin
        case (kind)
          FR_WREN:  hdrByte = OP_WREN;
          FR_ERASE: hdrByte = OP_SECT_ERASE;
          FR_PROG:  hdrByte = OP_PAGE_PROG;
          default:  hdrByte = OP_READ_STATUS;
        endcase
      end
      10'd1:   hdrByte = (kind == FR_POLL) ? 8'h00 : frameAddr[23:16];
      10'd2:   hdrByte = frameAddr[15:8];
      10'd3:   hdrByte = frameAddr[7:0];
      default: hdrByte = 8'h00;
    endcase
  end

  // Strobe generation: one action per cycle, only while the shifter is free
  always_comb begin
    strb    = '0;
    dataReq = 1'b0;
    if (state == ST_FRAME && ready) begin
      if (byteIdx == frameLen) begin
        strb.csOff = 1'b1;
      end else if (kind == FR_PROG && byteIdx >= 10'(HDR_N)) begin
        dataReq = 1'b1;
        if (dataVld) begin
          strb.send   = 1'b1;
          strb.txByte = dataIn;
        end
      end else begin
        strb.send   = 1'b1;
        strb.csOn   = (byteIdx == 10'd0);
        strb.txByte = hdrByte;
      end
    end
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kind       <= FR_WREN;
      byteIdx    <= '0;
      curAddr    <= '0;
      remaining  <= '0;
      lastSector <= '0;
      anyErased  <= 1'b0;
      eraseStep  <= 1'b0;
      pollCnt    <= '0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            curAddr   <= startAddr;
            remaining <= byteLen;
            anyErased <= 1'b0;
            error     <= 1'b0;
            state     <= (byteLen == '0) ? ST_DONE : ST_PLAN;
          end
        end

        ST_PLAN: begin
          byteIdx <= '0;
          kind    <= FR_WREN;
          state   <= ST_FRAME;
          if (!anyErased || curAddr[23:12] != lastSector) begin
            eraseStep  <= 1'b1;
            lastSector <= curAddr[23:12];
            anyErased  <= 1'b1;
          end else begin
            eraseStep <= 1'b0;
          end
        end

        ST_FRAME: begin
          if (strb.send) begin
            byteIdx <= byteIdx + 10'd1;
          end else if (strb.csOff) begin
            byteIdx <= '0;
            case (kind)
              FR_WREN:  kind <= eraseStep ? FR_ERASE : FR_PROG;
              FR_ERASE: begin
                kind    <= FR_POLL;
                pollCnt <= '0;
              end
              FR_PROG: begin
                kind      <= FR_POLL;
                pollCnt   <= '0;
                curAddr   <= curAddr + 24'(chunkLen);
                remaining <= LEN_W'(remExt - CMP_W'(chunkLen));
              end
              default: begin
                if (!statusBusy) begin
                  if (eraseStep) begin
                    eraseStep <= 1'b0;
                    kind      <= FR_WREN;
                  end else begin
                    state <= (remaining == '0) ? ST_DONE : ST_PLAN;
                  end
                end else if (pollCnt == PC_W'(POLL_MAX - 1)) begin
                  state <= ST_FAIL;
                end else begin
                  pollCnt <= pollCnt + PC_W'(1);
                end
              end
            endcase
          end
        end

        ST_DONE: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end

        default: begin
          error <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/flashProgSeq.sv
module flashProgSeq
  import flashSeqPkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int DESEL_CYC = 8,
  parameter int LEN_W     = 16,
  parameter int POLL_MAX  = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [23:0]      startAddr,
  input  logic [LEN_W-1:0] byteLen,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             dataReq,
  input  logic             dataVld,
  input  logic [7:0]       dataIn,
  output logic             sclk,
  output logic             csN,
  output logic             mosi,
  input  logic             miso
);

  spiStrobe_t strb;
  logic       ready;
  logic [7:0] rxByte;

  flashSeqCtrl #(
    .LEN_W   (LEN_W),
    .POLL_MAX(POLL_MAX)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .startAddr(startAddr),
    .byteLen  (byteLen),
    .dataVld  (dataVld),
    .dataIn   (dataIn),
    .ready    (ready),
    .rxByte   (rxByte),
    .strb     (strb),
    .dataReq  (dataReq),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  flashSpiShifter #(
    .HALF_DIV (HALF_DIV),
    .DESEL_CYC(DESEL_CYC)
  ) shifter (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .ready (ready),
    .rxByte(rxByte),
    .sclk  (sclk),
    .csN   (csN),
    .mosi  (mosi),
    .miso  (miso)
  );

endmodule

// File: rtl/flashProgSeqChk.sv
module flashProgSeqChk (
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic csN,
  input logic mosi,
  input logic dataReq,
  input logic busy,
  input logic done,
  input logic error
);

  // R1: data line holds steady through the high half of each SCLK period
  a_r1_mosi_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && !$rose(sclk)) |-> $stable(mosi));

  // R6: no clock activity while deselected
  a_r6_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R6: chip select releases only with the clock low
  a_r6_cs_release_clk_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> !sclk);

  // R7: bytes are requested only inside an open frame
  a_r7_req_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    dataReq |-> !csN);

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: when idle the flash is deselected
  a_r9_idle_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  // R8: abort and completion never coincide
  a_r8_done_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

endmodule

bind flashProgSeq flashProgSeqChk chk (
  .clk    (clk),
  .rstN   (rstN),
  .sclk   (sclk),
  .csN    (csN),
  .mosi   (mosi),
  .dataReq(dataReq),
  .busy   (busy),
  .done   (done),
  .error  (error)
);

// File: tb/flashProgSeq_test.sv
`timescale 1ns/1ps
module flashProgSeq_test;

  localparam int HALF  = 2;
  localparam int DESEL = 8;
  localparam int PMAX  = 8;
  localparam int LW    = 16;

  // {addr, len, expected erases, expected programs, busy polls per op}
  localparam logic [63:0] VEC [6] = '{
    {24'h001000, 16'd16,  8'd1, 8'd1, 8'd0},
    {24'h0010F0, 16'd32,  8'd1, 8'd2, 8'd2},
    {24'h002F80, 16'd256, 8'd2, 8'd2, 8'd1},
    {24'h005000, 16'd256, 8'd1, 8'd1, 8'd3},
    {24'h00A0FF, 16'd1,   8'd1, 8'd1, 8'd0},
    {24'h00BF01, 16'd600, 8'd2, 8'd3, 8'd5}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [23:0]   startAddr = '0;
  logic [LW-1:0] byteLen = '0;
  logic          dataVld = 1'b0;
  logic [7:0]    dataIn = '0;
  logic          busy, done, error, dataReq, sclk, csN, mosi, miso;

  always #10 clk = ~clk;

  flashProgSeq #(
    .HALF_DIV(HALF), .DESEL_CYC(DESEL), .LEN_W(LW), .POLL_MAX(PMAX)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .byteLen(byteLen), .busy(busy), .done(done), .error(error),
    .dataReq(dataReq), .dataVld(dataVld), .dataIn(dataIn),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 13 + (a >> 8) + 8'h3C);
  endfunction

  // ---------------- flash model ----------------
  logic [7:0] mem [int];
  bit         secErased [int];
  logic [7:0] fBytes [$];
  int  bitN = 0;
  logic [7:0] sh = '0;
  logic [7:0] misoSh = '0;
  int  eraseCnt, progCnt, pollCnt, frameCnt, viol, busyLeft, busyPolls, lastSec;
  bit  wel, pendIdle, busyForever;

  function automatic logic [7:0] rd(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  assign miso = misoSh[7];

  always @(negedge csN) begin
    bitN = 0;
    fBytes.delete();
  end

  always @(posedge sclk) if (!csN) begin
    sh = {sh[6:0], mosi};
    bitN++;
    if (bitN % 8 == 0) fBytes.push_back(sh);
  end

  always @(negedge sclk) if (!csN) begin
    if (bitN == 8 && fBytes.size() == 1 && fBytes[0] == 8'h05)
      misoSh = {7'b0, (busyForever || busyLeft > 0)};
    else
      misoSh = {misoSh[6:0], 1'b0};
  end

  task automatic processFrame();
    int n;
    int a;
    logic [7:0] op;
    n  = fBytes.size();
    op = fBytes[0];
    frameCnt++;
    if (bitN % 8 != 0) viol++;
    if (op != 8'h05 && pendIdle) viol++;
    case (op)
      8'h06: begin
        if (n != 1) viol++;
        wel = 1'b1;
      end
      8'h05: begin
        if (n != 2) viol++;
        pollCnt++;
        if (!busyForever) begin
          if (busyLeft > 0) busyLeft--;
          else pendIdle = 1'b0;
        end
      end
      8'h20: begin
        if (n != 4 || !wel) viol++;
        a = int'({fBytes[1], fBytes[2], fBytes[3]});
        if ((a & 32'hFFF) != 0) viol++;
        if (eraseCnt > 0 && (a >> 12) <= lastSec) viol++;
        lastSec = a >> 12;
        for (int i = 0; i < 4096; i++) mem[(a & ~32'hFFF) + i] = 8'hFF;
        secErased[a >> 12] = 1'b1;
        eraseCnt++;
        wel = 1'b0; pendIdle = 1'b1; busyLeft = busyPolls;
      end
      8'h02: begin
        if (n < 5 || n > 260 || !wel) viol++;
        a = int'({fBytes[1], fBytes[2], fBytes[3]});
        if ((a & 255) + (n - 4) > 256) viol++;
        if (!secErased.exists(a >> 12)) viol++;
        for (int i = 4; i < n; i++) mem[a + i - 4] = rd(a + i - 4) & fBytes[i];
        progCnt++;
        wel = 1'b0; pendIdle = 1'b1; busyLeft = busyPolls;
      end
      default: viol++;
    endcase
  endtask

  always @(posedge csN) if (fBytes.size() > 0) processFrame();

  // deselect time measured in system cycles, sampled away from the edge
  int hiCnt = 0, minHigh = 1000000;
  bit seenFrame = 1'b0;
  always @(negedge clk) begin
    if (csN) hiCnt++;
    else begin
      if (hiCnt > 0 && seenFrame && hiCnt < minHigh) minHigh = hiCnt;
      hiCnt = 0;
      seenFrame = 1'b1;
    end
  end

  // data responder with an irregular stall pattern
  int ptr = 0, runBase = 0;
  bit stall = 1'b0;
  initial forever begin
    @(negedge clk);
    if (dataReq && !stall) begin
      dataVld = 1'b1;
      dataIn  = pat(runBase + ptr);
      ptr++;
      stall = (ptr % 3 == 0);
    end else begin
      dataVld = 1'b0;
      stall = 1'b0;
    end
  end

  task automatic resetModel(input int bp, input bit forever_);
    eraseCnt = 0; progCnt = 0; pollCnt = 0; frameCnt = 0; viol = 0;
    busyLeft = 0; busyPolls = bp; busyForever = forever_; lastSec = 0;
    wel = 1'b0; pendIdle = 1'b0;
    secErased.delete();
    hiCnt = 0; minHigh = 1000000; seenFrame = 1'b0;
  endtask

  task automatic runSeq(input int addr, input int len, input bit stray,
                        output bit sawDone, output bit sawErr);
    @(negedge clk);
    startAddr = 24'(addr); byteLen = LW'(len);
    runBase = addr; ptr = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sawDone = 1'b0; sawErr = 1'b0;
    for (int c = 0; c < 60000 && !sawDone && !sawErr; c++) begin
      @(negedge clk);
      if (stray && c == 40) begin
        start = 1'b1; startAddr = 24'h7F0000; byteLen = LW'(5);
      end else start = 1'b0;
      if (done)  sawDone = 1'b1;
      if (error) sawErr  = 1'b1;
    end
    start = 1'b0;
    if (!sawDone && !sawErr) check(1'b0, "R9", "run never finished", 0, 1);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: bench hung, got no finish expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit d, e;
    int addr, len, ne, np, bp, bad, endA;

    resetModel(0, 1'b0);
    repeat (3) @(negedge clk);
    // R11: reset state
    check(csN == 1'b1, "R11", "csN in reset", csN, 1);
    check(sclk == 1'b0, "R11", "sclk in reset", sclk, 0);
    check({busy, done, error, dataReq} == 4'b0, "R11", "status in reset",
          {busy, done, error, dataReq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9: zero-length run
    resetModel(0, 1'b0);
    runSeq(24'h004000, 0, 1'b0, d, e);
    check(d && !e, "R9", "zero length done", d, 1);
    check(frameCnt == 0, "R9", "zero length frames", frameCnt, 0);

    // table of runs
    for (int v = 0; v < 6; v++) begin
      addr = int'(VEC[v][63:40]);
      len  = int'(VEC[v][39:24]);
      ne   = int'(VEC[v][23:16]);
      np   = int'(VEC[v][15:8]);
      bp   = int'(VEC[v][7:0]);
      resetModel(bp, 1'b0);
      runSeq(addr, len, 1'b1, d, e);
      check(d && !e, "R9", "run completes", {d, e}, 2);
      check(eraseCnt == ne, "R3", "erase count", eraseCnt, ne);
      check(progCnt == np, "R4", "program count", progCnt, np);
      check(viol == 0, "R2,R3,R4,R5", "protocol violations", viol, 0);
      check(pollCnt == (ne + np) * (bp + 1), "R5", "status polls",
            pollCnt, (ne + np) * (bp + 1));
      check(ptr == len, "R7,R10", "bytes taken", ptr, len);
      bad = 0;
      for (int i = 0; i < len; i++) if (rd(addr + i) != pat(addr + i)) bad++;
      check(bad == 0, "R1,R7", "data mismatches", bad, 0);
      check(minHigh >= DESEL, "R6", "min deselect cycles", minHigh, DESEL);
      if ((addr & 32'hFFF) != 0)
        check(rd(addr - 1) == 8'hFF, "R3", "byte below run erased", rd(addr - 1), 255);
      endA = addr + len;
      if ((endA & 32'hFFF) != 0)
        check(rd(endA) == 8'hFF, "R3", "byte above run erased", rd(endA), 255);
    end

    // R8: device never idles -> abort after PMAX polls
    resetModel(0, 1'b1);
    runSeq(24'h030000, 8, 1'b0, d, e);
    check(e && !d, "R8", "timeout raises error", {d, e}, 1);
    check(pollCnt == PMAX, "R8", "polls before abort", pollCnt, PMAX);
    check(progCnt == 0, "R8", "no program after abort", progCnt, 0);
    repeat (20) @(negedge clk);
    check(error == 1'b1 && csN == 1'b1 && busy == 1'b0, "R8", "error held, deselected",
          {error, csN, busy}, 6);

    // R8: idle on the last allowed poll succeeds and clears the error
    resetModel(PMAX - 1, 1'b0);
    runSeq(24'h020010, 4, 1'b0, d, e);
    check(d && !e, "R8", "idle on last poll completes", {d, e}, 2);
    check(error == 1'b0, "R8", "error cleared by start", error, 0);
    check(pollCnt == 2 * PMAX, "R5", "polls with late idle", pollCnt, 2 * PMAX);
    check(viol == 0, "R5", "late idle violations", viol, 0);
    bad = 0;
    for (int i = 0; i < 4; i++) if (rd(24'h020010 + i) != pat(24'h020010 + i)) bad++;
    check(bad == 0, "R7", "late idle data", bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule